// File: doc/BRIEF.md
# Framed Nibble Cell Receiver

This block takes in fixed-length cells arriving four bits at a time, with a framing strobe that marks where each cell starts. Data and strobe are both sampled on the rising edge of the port clock. Every edge that sees the strobe low carries one data nibble. While the strobe is high, the write position is held at the configured start address. Nibbles that follow are packed into bytes and written into one of two cell buffers. When the configured stop address is written, that buffer is marked full and the next cell goes to the other buffer.

A downstream reader sees which buffer holds the oldest complete cell. It reads that cell's bytes through a combinational byte port, then pops the buffer to release it. The block flags three faults:

- a cell cut short by an early strobe;
- a cell that runs past the stop address;
- a cell that arrives while both buffers are still occupied.

The three fault flags stay set until the reader clears them.

Top module: `nibble_cell_rx`

## Requirements
- R1: After reset, all full flags, the reader valid flag and all three error flags are 0, and the reader buffer index is 0.
- R2: Any edge with the strobe high moves the write position back to the start address and stores nothing. The first edge with the strobe low after that stores its nibble at the start address, however long the strobe was held high.
- R3: Nibble address n of a buffer lands in byte n/2. An even address fills bits [7:4] and an odd address fills bits [3:0]. The reader port returns byte rd_addr_i of the buffer named by rd_buf_o.
- R4: The edge that stores the nibble at the stop address completes the cell. The full flag of that buffer reads 1 from the next cycle on.
- R5: A strobe-high edge while a cell is partly received and the stop address has not been written raises the short error. That edge stores nothing and sets no full flag, and the next cell is written into the same buffer, overwriting the partial one.
- R6: A strobe-low edge right after a cell completes raises the long error. The completed cell stays full with its first nibbles intact, and every nibble up to the next strobe-high edge is discarded. The cell after that goes to the other buffer.
- R7: A strobe held high on the same edge as the stop nibble stores that nibble and completes the cell without error. The very next strobe-low edge starts a new cell in the other buffer.
- R8: Completed cells go to buffers 0, 1, 0, 1 and so on. rd_buf_o names the oldest full buffer, and a pop while rd_valid_o is 1 clears that buffer's full flag and moves rd_buf_o to the other buffer.
- R9: If the target buffer is still full when the first nibble of a new cell arrives, the overflow error is raised. The whole cell is discarded up to the next strobe-high edge, and the full flags are left unchanged.
- R10: Error flags are sticky. Bit 0 of err_clr_i clears the short flag, bit 1 the long flag and bit 2 the overflow flag. An error event in the same cycle as its clear wins.
- R11: A pop while rd_valid_o is 0 changes neither the full flags nor rd_buf_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Port clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frm_i | input | 1 | Framing strobe |
| nib_i | input | 4 | Data nibble |
| cfg_start_i | input | NA_W (7) | Nibble address of a cell's first nibble |
| cfg_stop_i | input | NA_W (7) | Nibble address of a cell's last nibble |
| rd_pop_i | input | 1 | Release the oldest full buffer |
| rd_addr_i | input | BA_W (6) | Byte address for the reader port |
| err_clr_i | input | 3 | Clear pulses: [0] short, [1] long, [2] overflow |
| full_o | output | 2 | Full flag of each buffer |
| rd_valid_o | output | 1 | Oldest buffer holds a complete cell |
| rd_buf_o | output | 1 | Index of the oldest full buffer |
| rd_data_o | output | 8 | Byte read from the oldest buffer |
| short_err_o | output | 1 | Sticky short-cell flag |
| long_err_o | output | 1 | Sticky long-cell flag |
| ovf_err_o | output | 1 | Sticky overflow flag |

## Verification
The assertions assume three things about the inputs:

- the start address is not above the stop address;
- the stop address lies inside one buffer;
- the configuration changes only while the block is held in reset.

Under those assumptions, no write can land past the stop address or into a full buffer. The stimulus keeps within them by changing the configuration only around a reset pulse, with start even and stop odd. Random cell lengths, strobe widths, back-to-back frames, pops and clears are mixed freely inside one configuration.

// File: rtl/nibble_cell_pkg.sv
package nibble_cell_pkg;
  typedef enum logic [2:0] {
    WS_IDLE,
    WS_ARM,
    WS_RECV,
    WS_DONE,
    WS_DROP
  } wr_state_e;

  localparam int unsigned ERR_SHORT = 0;
  localparam int unsigned ERR_LONG  = 1;
  localparam int unsigned ERR_OVF   = 2;
  localparam int unsigned N_ERR     = 3;
  localparam int unsigned N_BUF     = 2;
endpackage

// File: rtl/nc_wr_ctrl.sv
module nc_wr_ctrl
  import nibble_cell_pkg::*;
#(
  parameter int unsigned NA_W = 7
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            frm_i,
  input  logic [3:0]      nib_i,
  input  logic [NA_W-1:0] start_i,
  input  logic [NA_W-1:0] stop_i,
  input  logic [N_BUF-1:0] full_i,
  output logic            we_o,
  output logic            wbuf_o,
  output logic [NA_W-1:0] waddr_o,
  output logic [3:0]      wdata_o,
  output logic            done_o,
  output logic            done_buf_o,
  output logic [N_ERR-1:0] err_ev_o
);
  wr_state_e state_q, state_n;
  logic [NA_W-1:0] ptr_q, ptr_n;
  logic wbuf_q, wbuf_n;
  logic at_stop;

  assign at_stop = (ptr_q == stop_i);

  always_comb begin
    state_n  = state_q;
    ptr_n    = ptr_q;
    we_o     = 1'b0;
    done_o   = 1'b0;
    err_ev_o = '0;
    case (state_q)
      WS_IDLE, WS_DROP: begin
        if (frm_i) begin
          ptr_n   = start_i;
          state_n = WS_ARM;
        end
      end
      WS_DONE: begin
        if (frm_i) begin
          ptr_n   = start_i;
          state_n = WS_ARM;
        end else begin
          err_ev_o[ERR_LONG] = 1'b1;
          state_n = WS_DROP;
        end
      end
      WS_ARM: begin
        if (frm_i) begin
          ptr_n = start_i;
        end else if (full_i[wbuf_q]) begin
          err_ev_o[ERR_OVF] = 1'b1;
          state_n = WS_DROP;
        end else begin
          we_o = 1'b1;
          if (at_stop) begin
            done_o  = 1'b1;
            state_n = WS_DONE;
          end else begin
            ptr_n   = ptr_q + NA_W'(1);
            state_n = WS_RECV;
          end
        end
      end
      WS_RECV: begin
        if (frm_i) begin
          // frame on the stop nibble is a back-to-back cell, elsewhere it cuts the cell
          if (at_stop) begin
            we_o   = 1'b1;
            done_o = 1'b1;
          end else begin
            err_ev_o[ERR_SHORT] = 1'b1;
          end
          ptr_n   = start_i;
          state_n = WS_ARM;
        end else begin
          we_o = 1'b1;
          if (at_stop) begin
            done_o  = 1'b1;
            state_n = WS_DONE;
          end else begin
            ptr_n = ptr_q + NA_W'(1);
          end
        end
      end
      default: state_n = WS_IDLE;
    endcase
  end

  assign wbuf_n     = done_o ? ~wbuf_q : wbuf_q;
  assign wbuf_o     = wbuf_q;
  assign waddr_o    = ptr_q;
  assign wdata_o    = nib_i;
  assign done_buf_o = wbuf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= WS_IDLE;
      ptr_q   <= '0;
      wbuf_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      ptr_q   <= ptr_n;
      wbuf_q  <= wbuf_n;
    end
  end

  // R9
  no_write_into_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |-> !full_i[wbuf_o]);

  // R4
  write_within_cell_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |-> (waddr_o >= start_i && waddr_o <= stop_i));

  // R5
  err_events_exclusive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(err_ev_o));

  // R2
  frame_reloads_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frm_i && !we_o) |=> (waddr_o == $past(start_i)));
endmodule

// File: rtl/nc_cell_store.sv
module nc_cell_store
  import nibble_cell_pkg::*;
#(
  parameter int unsigned CELL_BYTES = 56,
  localparam int unsigned BA_W = $clog2(CELL_BYTES),
  localparam int unsigned NA_W = BA_W + 1,
  localparam int unsigned NIBS = 2 * CELL_BYTES
) (
  input  logic            clk_i,
  input  logic            we_i,
  input  logic            wbuf_i,
  input  logic [NA_W-1:0] waddr_i,
  input  logic [3:0]      wdata_i,
  input  logic            rbuf_i,
  input  logic [BA_W-1:0] raddr_i,
  output logic [7:0]      rdata_o
);
  logic [3:0] mem_q [N_BUF][NIBS];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[wbuf_i][waddr_i] <= wdata_i;
  end

  // even nibble address is the high half of the byte
  assign rdata_o = {mem_q[rbuf_i][{raddr_i, 1'b0}], mem_q[rbuf_i][{raddr_i, 1'b1}]};
endmodule

// File: rtl/nc_rd_ctrl.sv
module nc_rd_ctrl
  import nibble_cell_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_i,
  input  logic             set_buf_i,
  input  logic             pop_i,
  output logic [N_BUF-1:0] full_o,
  output logic             rd_buf_o,
  output logic             rd_valid_o
);
  logic [N_BUF-1:0] full_q, full_n;
  logic rd_q, pop_ok;

  assign pop_ok = pop_i & full_q[rd_q];

  always_comb begin
    full_n = full_q;
    if (pop_ok) full_n[rd_q] = 1'b0;
    if (set_i)  full_n[set_buf_i] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= '0;
      rd_q   <= 1'b0;
    end else begin
      full_q <= full_n;
      rd_q   <= rd_q ^ pop_ok;
    end
  end

  assign full_o     = full_q;
  assign rd_buf_o   = rd_q;
  assign rd_valid_o = full_q[rd_q];

  // R8
  complete_into_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |-> !full_o[set_buf_i]);

  // R8
  pop_releases_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && rd_valid_o) |=> (!full_o[$past(rd_buf_o)] && rd_buf_o != $past(rd_buf_o)));

  // R11
  idle_pop_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !rd_valid_o && !set_i) |=> (full_o == $past(full_o) && $stable(rd_buf_o)));
endmodule

// File: rtl/nc_err_flags.sv
module nc_err_flags #(
  parameter int unsigned N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] ev_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  for (genvar gi = 0; gi < N; gi++) begin : g_flag
    logic flag_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flag_q <= 1'b0;
      else         flag_q <= ev_i[gi] | (flag_q & ~clr_i[gi]);
    end
    assign flag_o[gi] = flag_q;

    // R10
    event_sets_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ev_i[gi] |=> flag_o[gi]);

    // R10
    flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_o[gi] && !clr_i[gi]) |=> flag_o[gi]);
  end
endmodule

// File: rtl/nibble_cell_rx.sv
module nibble_cell_rx
  import nibble_cell_pkg::*;
#(
  parameter int unsigned CELL_BYTES = 56,
  localparam int unsigned BA_W = $clog2(CELL_BYTES),
  localparam int unsigned NA_W = BA_W + 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            frm_i,
  input  logic [3:0]      nib_i,
  input  logic [NA_W-1:0] cfg_start_i,
  input  logic [NA_W-1:0] cfg_stop_i,
  input  logic            rd_pop_i,
  input  logic [BA_W-1:0] rd_addr_i,
  input  logic [2:0]      err_clr_i,
  output logic [1:0]      full_o,
  output logic            rd_valid_o,
  output logic            rd_buf_o,
  output logic [7:0]      rd_data_o,
  output logic            short_err_o,
  output logic            long_err_o,
  output logic            ovf_err_o
);
  logic            we, wbuf, done, done_buf;
  logic [NA_W-1:0] waddr;
  logic [3:0]      wdata;
  logic [N_ERR-1:0] err_ev, err_flag;
  logic [N_BUF-1:0] full;

  nc_wr_ctrl #(.NA_W(NA_W)) i_wr (
    .clk_i, .rst_ni, .frm_i, .nib_i,
    .start_i(cfg_start_i), .stop_i(cfg_stop_i), .full_i(full),
    .we_o(we), .wbuf_o(wbuf), .waddr_o(waddr), .wdata_o(wdata),
    .done_o(done), .done_buf_o(done_buf), .err_ev_o(err_ev)
  );

  nc_cell_store #(.CELL_BYTES(CELL_BYTES)) i_store (
    .clk_i, .we_i(we), .wbuf_i(wbuf), .waddr_i(waddr), .wdata_i(wdata),
    .rbuf_i(rd_buf_o), .raddr_i(rd_addr_i), .rdata_o(rd_data_o)
  );

  nc_rd_ctrl i_rd (
    .clk_i, .rst_ni, .set_i(done), .set_buf_i(done_buf), .pop_i(rd_pop_i),
    .full_o(full), .rd_buf_o(rd_buf_o), .rd_valid_o(rd_valid_o)
  );

  nc_err_flags #(.N(N_ERR)) i_err (
    .clk_i, .rst_ni, .ev_i(err_ev), .clr_i(err_clr_i), .flag_o(err_flag)
  );

  assign full_o      = full;
  assign short_err_o = err_flag[ERR_SHORT];
  assign long_err_o  = err_flag[ERR_LONG];
  assign ovf_err_o   = err_flag[ERR_OVF];

  // R4
  done_marks_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |=> full_o[$past(done_buf)]);

  // R9
  overflow_keeps_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_ev[ERR_OVF] && !rd_pop_i) |=> (full_o == $past(full_o)));
endmodule

// File: tb/test_nibble_cell_rx.sv
`timescale 1ns/1ps
module test_nibble_cell_rx;
  localparam int CB   = 56;
  localparam int NIBS = 2 * CB;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       frm = 1'b0;
  logic [3:0] nib = '0;
  logic [6:0] cfg_start = 7'd2, cfg_stop = 7'd9;
  logic       pop = 1'b0;
  logic [5:0] rd_addr = '0;
  logic [2:0] clr = '0;
  logic [1:0] full;
  logic       rd_valid, rd_buf;
  logic [7:0] rd_data;
  logic       short_err, long_err, ovf_err;

  int n_vec = 0, n_bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  nibble_cell_rx #(.CELL_BYTES(CB)) i_nibble_cell_rx (
    .clk_i(clk), .rst_ni, .frm_i(frm), .nib_i(nib),
    .cfg_start_i(cfg_start), .cfg_stop_i(cfg_stop), .rd_pop_i(pop),
    .rd_addr_i(rd_addr), .err_clr_i(clr), .full_o(full),
    .rd_valid_o(rd_valid), .rd_buf_o(rd_buf), .rd_data_o(rd_data),
    .short_err_o(short_err), .long_err_o(long_err), .ovf_err_o(ovf_err)
  );

  // reference model, built from the requirements
  int         m_st;   // 0 idle, 1 arm, 2 recv, 3 done, 4 drop
  int         m_ptr;
  bit         m_wb, m_rd;
  bit [1:0]   m_full;
  bit [2:0]   m_err;
  logic [3:0] m_mem [2][NIBS];
  int         lo_b, hi_b;

  function automatic logic [7:0] exp_byte(bit b, int a);
    return {m_mem[b][2*a], m_mem[b][2*a+1]};
  endfunction

  task automatic model_reset();
    m_st = 0; m_ptr = 0; m_wb = 0; m_rd = 0; m_full = '0; m_err = '0;
  endtask

  task automatic model_step(bit f, logic [3:0] n, bit p, bit [2:0] c);
    bit [2:0] ev = '0;
    bit done = 0;
    bit [1:0] fpre = m_full;
    int stop = int'(cfg_stop);
    case (m_st)
      0, 4: if (f) begin m_ptr = cfg_start; m_st = 1; end
      3: if (f) begin m_ptr = cfg_start; m_st = 1; end
         else begin ev[1] = 1; m_st = 4; end
      1: if (f) m_ptr = cfg_start;
         else if (fpre[m_wb]) begin ev[2] = 1; m_st = 4; end
         else begin
           m_mem[m_wb][m_ptr] = n;
           if (m_ptr == stop) begin done = 1; m_st = 3; end
           else begin m_ptr++; m_st = 2; end
         end
      2: if (f) begin
           if (m_ptr == stop) begin m_mem[m_wb][m_ptr] = n; done = 1; end
           else ev[0] = 1;
           m_ptr = cfg_start; m_st = 1;
         end else begin
           m_mem[m_wb][m_ptr] = n;
           if (m_ptr == stop) begin done = 1; m_st = 3; end
           else m_ptr++;
         end
      default: m_st = 0;
    endcase
    if (p && fpre[m_rd]) begin m_full[m_rd] = 0; m_rd = ~m_rd; end
    if (done) begin m_full[m_wb] = 1; m_wb = ~m_wb; end
    m_err = (m_err & ~c) | ev;
  endtask

  task automatic chk(string tag, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("R4 full_o", full, m_full);
    chk("R8 rd_valid_o", rd_valid, m_full[m_rd]);
    chk("R8 rd_buf_o", rd_buf, m_rd);
    chk("R5 short_err_o", short_err, m_err[0]);
    chk("R6 long_err_o", long_err, m_err[1]);
    chk("R9 ovf_err_o", ovf_err, m_err[2]);
    if (m_full[m_rd]) begin
      int a = lo_b + int'($urandom % (hi_b - lo_b + 1));
      rd_addr = 6'(a);
      #1;
      chk("R3 rd_data_o", rd_data, exp_byte(m_rd, a));
    end
  endtask

  task automatic cyc(bit f, logic [3:0] n, bit p, bit [2:0] c);
    @(negedge clk);
    compare_all();
    frm = f; nib = n; pop = p; clr = c;
    @(posedge clk);
    model_step(f, n, p, c);
    #1;
  endtask

  task automatic do_reset(int s, int e);
    @(negedge clk);
    rst_ni = 1'b0; frm = 0; pop = 0; clr = 0;
    cfg_start = 7'(s); cfg_stop = 7'(e);
    lo_b = s / 2; hi_b = e / 2;
    model_reset();
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic send_frame(int k);
    for (int i = 0; i < k; i++) cyc(1, 4'hF, 0, 0);
  endtask

  task automatic send_cell(int base, int len, bit last_frm);
    for (int i = 0; i < len; i++) cyc(last_frm && i == len - 1, 4'(base + i), 0, 0);
  endtask

  task automatic rd_chk(string tag, int a, int exp);
    rd_addr = 6'(a);
    #1;
    chk(tag, rd_data, exp);
  endtask

  task automatic random_run(int s, int e, int cycles);
    int nom = e - s + 1;
    bit bb = 0;
    int t = 0;
    do_reset(s, e);
    while (t < cycles) begin
      int d = int'($urandom % 6) - 3;
      int len = (nom + d < 1) ? 1 : nom + d;
      bit nbb = (d == 0) && ($urandom % 2 == 1);
      if (!bb) begin
        int k = 1 + int'($urandom % 2);
        for (int i = 0; i < k; i++) begin
          cyc(1, 4'($urandom), ($urandom % 4) == 0, ($urandom % 25 == 0) ? 3'($urandom) : 3'b0);
          t++;
        end
      end
      for (int i = 0; i < len; i++) begin
        cyc(nbb && i == len - 1, 4'($urandom), ($urandom % 4) == 0,
            ($urandom % 25 == 0) ? 3'($urandom) : 3'b0);
        t++;
      end
      bb = nbb;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_c311));
    do_reset(2, 9);
    #1;
    chk("R1 full_o", full, 0);
    chk("R1 rd_valid_o", rd_valid, 0);
    chk("R1 rd_buf_o", rd_buf, 0);
    chk("R1 errors", {ovf_err, long_err, short_err}, 0);

    // R2: long strobe with junk nibbles, then cell 1..8
    send_frame(3);
    send_cell(1, 8, 0);
    chk("R4 full after first cell", full, 2'b01);
    rd_chk("R2 first nibble at start", 1, 8'h12);
    rd_chk("R3 last byte packing", 4, 8'h78);

    // R7: back-to-back, strobe on the stop nibble
    send_frame(1);
    send_cell(9, 8, 1);
    chk("R7 both full", full, 2'b11);
    chk("R7 no errors", {ovf_err, long_err, short_err}, 0);

    // R9: third cell with both buffers full
    send_cell(3, 8, 0);
    chk("R9 ovf_err_o", ovf_err, 1);
    chk("R9 full unchanged", full, 2'b11);

    // R8: pop oldest (buffer 0)
    cyc(0, 4'h0, 1, 0);
    chk("R8 full after pop", full, 2'b10);
    chk("R8 rd_buf after pop", rd_buf, 1);
    rd_chk("R8 second cell data", 1, 8'h9A);

    // R5: short cell then a good cell into the same buffer
    send_frame(1);
    send_cell(5, 3, 0);
    send_frame(1);
    chk("R5 short_err_o", short_err, 1);
    chk("R5 full unchanged", full, 2'b10);
    send_cell(2, 8, 0);
    chk("R5 cell completed", full, 2'b11);
    cyc(1, 4'hF, 1, 0);
    chk("R8 rd_buf back to 0", rd_buf, 0);
    rd_chk("R5 partial overwritten", 1, 8'h23);

    // R10: selective clears
    cyc(1, 4'hF, 0, 3'b001);
    chk("R10 short cleared", short_err, 0);
    chk("R10 ovf kept", ovf_err, 1);
    cyc(1, 4'hF, 0, 3'b110);
    chk("R10 all cleared", {ovf_err, long_err, short_err}, 0);

    // R6: long cell keeps head, next cell into other buffer
    cyc(1, 4'hF, 1, 0);
    chk("R8 all empty", full, 2'b00);
    send_cell(1, 10, 0);
    chk("R6 long_err_o", long_err, 1);
    chk("R6 full", full, 2'b10);
    chk("R6 rd_buf", rd_buf, 1);
    rd_chk("R6 head kept", 4, 8'h78);
    send_frame(1);
    send_cell(3, 8, 0);
    chk("R6 next cell other buffer", full, 2'b11);

    // R11: pops with nothing valid
    send_frame(1);
    cyc(1, 4'hF, 1, 0);
    cyc(1, 4'hF, 1, 0);
    chk("R11 emptied", full, 2'b00);
    cyc(1, 4'hF, 1, 0);
    chk("R11 full unchanged", full, 2'b00);
    chk("R11 rd_buf unchanged", rd_buf, 1);
    chk("R11 rd_valid_o", rd_valid, 0);

    random_run(0, NIBS - 1, 4000);
    random_run(4, 15, 3000);
    random_run(6, 7, 1000);

    @(negedge clk);
    compare_all();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule